// File: doc/BRIEF.md
# Interrupt Status and Enable Unit

This block collects event pulses from the transmit and receive engines of a serial link controller. Each event sets a sticky bit in an 8-bit status register. A matching 8-bit enable register masks these bits, and the masked result drives one registered interrupt request line.

Software reaches both registers through a byte-wide register port. The read path is combinational on the address. A write takes effect at the clock edge. Status bits are cleared by writing ones to them. The enable register is a plain read/write mask. Of the two sub-events that describe a finished transmit slot, transmit-done is recorded only when that slot requested an event.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, status bits 7:3 and enable bits 7:3 are zero and `irq_out` is low.
- R2: Bits 2:0 of the status register (address 0) and of the enable register (address 1) always read as 1, and writes to those bits have no effect.
- R3: A one-cycle event pulse sets its status bit at the next clock edge, whatever the enable bit holds. The bit then stays set until it is cleared by software.
- R4: Writing the status register clears each bit 7:3 written as 1 and leaves each bit written as 0 unchanged.
- R5: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: Status bit 7 (transmit done) is set only when `ev_tx_done` and `ev_tx_slot_req` are both high in the same cycle.
- R7: Writing the enable register loads bits 7:3 from the write data, and those bits read back as written.
- R8: `irq_out` is registered. In each cycle it equals the OR over bits 7:3 of (status AND enable) as they stood in the previous cycle.
- R9: Status bit positions are: 7 transmit done, 6 receive done, 5 transmit underflow, 4 receive overflow, 3 serial gap received. The enable register uses the same layout.
- R10: A read of any address other than 0 or 1 returns zero. A write to such an address changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (2) | Register address: 0 status, 1 enable |
| reg_wr_en | input | 1 | Write strobe for the addressed register |
| reg_wr_data | input | 8 | Write data |
| reg_rd_data | output | 8 | Read data of the addressed register |
| ev_tx_done | input | 1 | Transmit slot completed (pulse) |
| ev_tx_slot_req | input | 1 | Completed slot asked for a done event |
| ev_rx_done | input | 1 | Receive completed (pulse) |
| ev_tx_under | input | 1 | Transmit FIFO underflow (pulse) |
| ev_rx_over | input | 1 | Receive FIFO overflow (pulse) |
| ev_gap | input | 1 | Serial gap received (pulse) |
| irq_out | output | 1 | Interrupt request |

## Verification
The assertions check four things on every cycle. A set status bit holds unless it is cleared, and an event always leaves its bit set, including when a clear arrives in the same cycle. Transmit-done never rises without the slot request. The enable mask and the interrupt line follow their one-cycle rules. The bench's scenarios cover the rest: the exact bit layout seen through reads, the fixed ones in the low bits, write-one-to-clear with mixed masks, and writes to unmapped addresses. It checks these against a reference model that runs under random and directed stimulus.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
   localparam int REG_W    = 8;
   localparam int N_SRC    = 5;
   localparam int LOW_W    = REG_W - N_SRC;
   // source index inside the 5-bit event vector (bit = index + LOW_W)
   localparam int SRC_TXDONE = 4;
   localparam int SRC_RXDONE = 3;
   localparam int SRC_TXUND  = 2;
   localparam int SRC_RXOVR  = 1;
   localparam int SRC_GAP    = 0;
endpackage

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit
   import irq_unit_pkg::*;
#(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= RST_VAL;
      else if (set_i)  q_o <= 1'b1;
      else if (clr_i)  q_o <= 1'b0;
   end

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o && !clr_i) |=> q_o); // R3
   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o); // R5
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= '0;
      else if (wr_i) q_o <= d_i;
   end

   AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(q_o)); // R7
   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (q_o == $past(d_i))); // R7
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
   parameter int W          = 5,
   parameter bit REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] stat_i,
   input  logic [W-1:0] en_i,
   output logic         irq_o
);
   logic pend;
   assign pend = |(stat_i & en_i);

   generate
      if (REGISTERED) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= pend;
         end
         assign irq_o = irq_q;
         AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            pend |=> irq_o); // R8
         AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !pend |=> !irq_o); // R8
      end else begin : g_comb
         assign irq_o = pend;
      end
   endgenerate
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
   import irq_unit_pkg::*;
#(
   parameter int ADDR_W    = 2,
   parameter int STAT_ADDR = 0,
   parameter int EN_ADDR   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr_en,
   input  logic [REG_W-1:0]  reg_wr_data,
   output logic [REG_W-1:0]  reg_rd_data,
   input  logic              ev_tx_done,
   input  logic              ev_tx_slot_req,
   input  logic              ev_rx_done,
   input  logic              ev_tx_under,
   input  logic              ev_rx_over,
   input  logic              ev_gap,
   output logic              irq_out
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_ADDR);
   localparam logic [LOW_W-1:0]  ONES   = '1;

   generate
      if (STAT_ADDR == EN_ADDR) begin : g_bad_addr
         $error("status and enable addresses must differ");
      end
      if (STAT_ADDR >= (1 << ADDR_W) || EN_ADDR >= (1 << ADDR_W)) begin : g_bad_w
         $error("register address does not fit ADDR_W");
      end
   endgenerate

   logic [N_SRC-1:0] src_ev;
   logic [N_SRC-1:0] stat_q;
   logic [N_SRC-1:0] en_q;
   logic             wr_stat, wr_en;

   assign src_ev[SRC_TXDONE] = ev_tx_done & ev_tx_slot_req;
   assign src_ev[SRC_RXDONE] = ev_rx_done;
   assign src_ev[SRC_TXUND]  = ev_tx_under;
   assign src_ev[SRC_RXOVR]  = ev_rx_over;
   assign src_ev[SRC_GAP]    = ev_gap;

   assign wr_stat = reg_wr_en && (reg_addr == A_STAT);
   assign wr_en   = reg_wr_en && (reg_addr == A_EN);

   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_src
         irq_sticky_bit #(.RST_VAL(1'b0)) u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (src_ev[i]),
            .clr_i (wr_stat & reg_wr_data[i+LOW_W]),
            .q_o   (stat_q[i])
         );
      end
   endgenerate

   irq_enable_reg #(.W(N_SRC)) u_en (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_i  (wr_en),
      .d_i   (reg_wr_data[REG_W-1:LOW_W]),
      .q_o   (en_q)
   );

   irq_req_gen #(.W(N_SRC), .REGISTERED(1'b1)) u_req (
      .clk    (clk),
      .rst_n  (rst_n),
      .stat_i (stat_q),
      .en_i   (en_q),
      .irq_o  (irq_out)
   );

   always_comb begin
      if (reg_addr == A_STAT)    reg_rd_data = {stat_q, ONES};
      else if (reg_addr == A_EN) reg_rd_data = {en_q, ONES};
      else                       reg_rd_data = '0;
   end

   always_comb begin
      if (rst_n && (reg_addr == A_STAT || reg_addr == A_EN))
         AST_LOW_ONES: assert (reg_rd_data[LOW_W-1:0] == ONES); // R2
   end

   AST_TXDONE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!(ev_tx_done && ev_tx_slot_req) && !stat_q[SRC_TXDONE])
      |=> !stat_q[SRC_TXDONE]); // R6
   AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr != A_STAT && reg_addr != A_EN) |=> $stable(en_q)); // R10
endmodule

// File: tb/irq_status_unit_test.sv
module irq_status_unit_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = '0;
   logic       reg_wr_en = 1'b0;
   logic [7:0] reg_wr_data = '0;
   logic [7:0] reg_rd_data;
   logic       ev_tx_done = 0, ev_tx_slot_req = 0, ev_rx_done = 0;
   logic       ev_tx_under = 0, ev_rx_over = 0, ev_gap = 0;
   logic       irq_out;

   int checks = 0;
   int failures = 0;
   logic [7:0] m_stat = 8'h07;
   logic [7:0] m_en   = 8'h07;
   logic       m_irq  = 1'b0;

   always #4 clk = ~clk;

   irq_status_unit uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
      .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
      .ev_tx_done(ev_tx_done), .ev_tx_slot_req(ev_tx_slot_req),
      .ev_rx_done(ev_rx_done), .ev_tx_under(ev_tx_under),
      .ev_rx_over(ev_rx_over), .ev_gap(ev_gap), .irq_out(irq_out)
   );

   function automatic logic [7:0] next_stat(logic [7:0] s, logic [4:0] ev,
         logic slot, logic wr, logic [1:0] a, logic [7:0] d);
      logic [7:0] set_m, n;
      set_m = {ev[4] & slot, ev[3:0], 3'b000};
      n = s;
      if (wr && a == 2'd0) n = n & ~{d[7:3], 3'b000};
      n = n | set_m | 8'h07;
      return n;
   endfunction

   function automatic logic [7:0] next_en(logic [7:0] e, logic wr,
         logic [1:0] a, logic [7:0] d);
      return (wr && a == 2'd1) ? {d[7:3], 3'b111} : e;
   endfunction

   task automatic chk(input logic ok, input string req, input logic [7:0] act,
                      input logic [7:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      #1 chk(irq_out === m_irq, {req, " R8 irq"}, {7'd0, irq_out}, {7'd0, m_irq});
      reg_addr = 2'd0;
      #1 chk(reg_rd_data === m_stat, {req, " R9 status"}, reg_rd_data, m_stat);
      reg_addr = 2'd1;
      #1 chk(reg_rd_data === m_en, {req, " R7 enable"}, reg_rd_data, m_en);
      reg_addr = 2'd2;
      #1 chk(reg_rd_data === 8'h00, {req, " R10 unmapped"}, reg_rd_data, 8'h00);
   endtask

   task automatic step(input logic [4:0] ev, input logic slot, input logic wr,
                       input logic [1:0] a, input logic [7:0] d, input string req);
      {ev_tx_done, ev_rx_done, ev_tx_under, ev_rx_over, ev_gap} = ev;
      ev_tx_slot_req = slot;
      reg_wr_en = wr; reg_addr = a; reg_wr_data = d;
      @(posedge clk);
      m_irq  = |(m_stat[7:3] & m_en[7:3]);
      m_stat = next_stat(m_stat, ev, slot, wr, a, d);
      m_en   = next_en(m_en, wr, a, d);
      #1;
      {ev_tx_done, ev_rx_done, ev_tx_under, ev_rx_over, ev_gap} = '0;
      ev_tx_slot_req = 0; reg_wr_en = 0;
      check_all(req);
   endtask

   initial begin
      #(8 * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      #20;
      check_all("R1 reset");
      chk(irq_out === 1'b0, "R1 irq low", {7'd0, irq_out}, 8'h00);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 after release");
      // R6: transmit done without slot request is ignored
      step(5'b10000, 1'b0, 0, 2'd0, 8'h00, "R6 no req");
      step(5'b10000, 1'b1, 0, 2'd0, 8'h00, "R6 with req");
      // R3: masked events still latch; each bit position R9
      step(5'b01000, 0, 0, 2'd0, 8'h00, "R3 rxdone");
      step(5'b00100, 0, 0, 2'd0, 8'h00, "R3 txunder");
      step(5'b00010, 0, 0, 2'd0, 8'h00, "R3 rxover");
      step(5'b00001, 0, 0, 2'd0, 8'h00, "R3 gap");
      step(5'b00000, 0, 0, 2'd0, 8'h00, "R3 hold");
      // R4: write zero leaves, write one clears
      step(5'b00000, 0, 1, 2'd0, 8'h07, "R4 zeros");
      step(5'b00000, 0, 1, 2'd0, 8'hA0, "R4 partial clear");
      // R5: event beats clear
      step(5'b00010, 0, 1, 2'd0, 8'h10, "R5 collision");
      // R2: low bits writes ignored
      step(5'b00000, 0, 1, 2'd1, 8'h00, "R2 en zero");
      step(5'b00000, 0, 1, 2'd1, 8'h07, "R2 en low");
      // R7 / R8: enable and irq timing
      step(5'b00000, 0, 1, 2'd1, 8'h10, "R7 en rxover");
      step(5'b00000, 0, 0, 2'd0, 8'h00, "R8 irq lag");
      step(5'b00000, 0, 1, 2'd0, 8'hF8, "R8 clear all");
      step(5'b00000, 0, 0, 2'd0, 8'h00, "R8 irq drop");
      // R10: unmapped writes
      step(5'b00000, 0, 1, 2'd2, 8'hFF, "R10 write a2");
      step(5'b00000, 0, 1, 2'd3, 8'hFF, "R10 write a3");
      for (int i = 0; i < 400; i++) begin
         logic [4:0] ev;
         ev = 5'($urandom) & 5'($urandom);
         step(ev, 1'($urandom), ($urandom % 3) == 0, 2'($urandom), 8'($urandom),
              "R3 R4 R5 R6 random");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule